// File: doc/BRIEF.md
# ADC Sample Reconstruction Front End

This block turns raw 12-bit converter codes from four sensor channels into signed Q16.16 physical quantities for the downstream control loops. The channels are battery voltage, boost bus voltage, grid voltage and grid current. Each channel arrives with its own code and a one-cycle valid strobe. The channels may be strobed independently or together.

The two DC channels are scaled straight from the code. The two AC channels were level-shifted to mid-scale before conversion, so the mid-scale code is removed first. Each channel is multiplied by its own Q16.16 scale factor, and the product saturates to the 32-bit signed range. The three voltage channels are then smoothed by a first-order low-pass filter. The grid current passes through unfiltered, because its ripple content shifts in frequency.

The filtered grid voltage is also multiplied by a reciprocal-peak gain. This gives a per-unit copy of the grid waveform that serves as the current reference.

Top module: `adc_recon`

## Requirements
- R1: While rst_n is low, every value output and every valid output is 0, and the filter states are cleared to 0.
- R2: Each output valid (vbat_qv, vbus_qv, vgrid_qv, igrid_qv, ref_qv) is high exactly in the cycle after its input valid was high at a rising clock edge, and at no other time; ref_qv follows vgrid_vld.
- R3: The battery and bus channels take no offset: the sample is code × scale, where the code is read as unsigned 0..4095 and the scale is a signed Q16.16 parameter. The result is Q16.16.
- R4: The grid voltage and grid current channels subtract 2048 from the code before scaling, so code 2048 maps to 0 and code 0 maps to −2048 × scale.
- R5: A scaled sample that exceeds the signed 32-bit range is clamped to 0x7FFFFFFF or 0x80000000, and never wraps. The same clamp applies to the reference.
- R6: Each voltage channel output is a first-order low-pass state y that starts at 0. On each valid sample x it updates to y + ((x − y) >>> 4), using a floor arithmetic shift.
- R7: The grid current output is the scaled sample itself, with no filtering, so a step appears in full one cycle after its strobe.
- R8: ref_q equals the clamp of (new filtered grid voltage × REF_GAIN) >>> 16, using a floor arithmetic shift. It is updated with the grid voltage.
- R9: When a channel's input valid is low, its value output (and for the grid voltage, also ref_q) keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbat_code | input | 12 | Battery voltage code |
| vbat_vld | input | 1 | Battery code strobe |
| vbus_code | input | 12 | Bus voltage code |
| vbus_vld | input | 1 | Bus code strobe |
| vgrid_code | input | 12 | Grid voltage code (mid-scale biased) |
| vgrid_vld | input | 1 | Grid voltage code strobe |
| igrid_code | input | 12 | Grid current code (mid-scale biased) |
| igrid_vld | input | 1 | Grid current code strobe |
| vbat_q | output | 32 | Filtered battery voltage, Q16.16 |
| vbat_qv | output | 1 | Battery output strobe |
| vbus_q | output | 32 | Filtered bus voltage, Q16.16 |
| vbus_qv | output | 1 | Bus output strobe |
| vgrid_q | output | 32 | Filtered grid voltage, Q16.16 |
| vgrid_qv | output | 1 | Grid voltage output strobe |
| igrid_q | output | 32 | Grid current, Q16.16 |
| igrid_qv | output | 1 | Grid current output strobe |
| ref_q | output | 32 | Per-unit grid reference, Q16.16 |
| ref_qv | output | 1 | Reference strobe |

## Verification
Repeated full-scale and then zero codes on the battery channel trace the exponential approach and decay. This shows whether the filter's floor shift and its state handling are correct.

A triangle of codes on the grid voltage channel swings through mid-scale to both rails. This separates correct offset removal from an unsigned read, and it exercises the reference gain on negative values.

The grid current is driven with mid-scale, one-step, both-rail and back-to-back codes, using a scale large enough to clip at both rails. This shows an unfiltered path and tells clamping apart from wraparound.

Mixed strobes on all channels, followed by idle cycles, check that the channels update independently and hold their values between samples.

// File: rtl/adc_recon.sv
module adc_recon #(
  parameter int CODE_W = 12,
  parameter int FRAC_W = 16,
  parameter int OUT_W = 32,
  parameter int IIR_SHIFT = 4,
  parameter logic signed [OUT_W-1:0] SCALE_VBAT = 960,
  parameter logic signed [OUT_W-1:0] SCALE_VBUS = 1600,
  parameter logic signed [OUT_W-1:0] SCALE_VGRID = 6400,
  parameter logic signed [OUT_W-1:0] SCALE_IGRID = 960,
  parameter logic signed [OUT_W-1:0] REF_GAIN = 327
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vbat_code,
  input  logic              vbat_vld,
  input  logic [CODE_W-1:0] vbus_code,
  input  logic              vbus_vld,
  input  logic [CODE_W-1:0] vgrid_code,
  input  logic              vgrid_vld,
  input  logic [CODE_W-1:0] igrid_code,
  input  logic              igrid_vld,
  output logic [OUT_W-1:0]  vbat_q,
  output logic              vbat_qv,
  output logic [OUT_W-1:0]  vbus_q,
  output logic              vbus_qv,
  output logic [OUT_W-1:0]  vgrid_q,
  output logic              vgrid_qv,
  output logic [OUT_W-1:0]  igrid_q,
  output logic              igrid_qv,
  output logic [OUT_W-1:0]  ref_q,
  output logic              ref_qv
);
  localparam int NCH = 4;
  localparam int W2 = 2 * OUT_W;
  localparam int MID = 1 << (CODE_W - 1);
  localparam logic signed [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic signed [OUT_W-1:0] SC [NCH] = '{SCALE_VBAT, SCALE_VBUS, SCALE_VGRID, SCALE_IGRID};
  localparam bit AC [NCH] = '{1'b0, 1'b0, 1'b1, 1'b1};
  localparam bit FILT [NCH] = '{1'b1, 1'b1, 1'b1, 1'b0};

  function automatic logic signed [OUT_W-1:0] sat(input logic signed [W2-1:0] p);
    if (p > W2'(MAXV)) return MAXV;
    if (p < W2'(MINV)) return MINV;
    return p[OUT_W-1:0];
  endfunction

  logic [CODE_W-1:0]        code [NCH];
  logic                     vld  [NCH];
  logic signed [OUT_W-1:0]  y    [NCH];
  logic                     yv   [NCH];
  logic signed [OUT_W-1:0]  nxt  [NCH];

  assign code[0] = vbat_code;
  assign code[1] = vbus_code;
  assign code[2] = vgrid_code;
  assign code[3] = igrid_code;
  assign vld[0] = vbat_vld;
  assign vld[1] = vbus_vld;
  assign vld[2] = vgrid_vld;
  assign vld[3] = igrid_vld;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic signed [CODE_W:0]  cen;
    logic signed [W2-1:0]    prod;
    logic signed [OUT_W-1:0] x;

    if (AC[i]) begin : g_ac
      assign cen = $signed({1'b0, code[i]}) - $signed((CODE_W+1)'(MID));
    end else begin : g_dc
      assign cen = $signed({1'b0, code[i]});
    end

    assign prod = W2'(cen) * W2'(SC[i]);
    assign x = sat(prod);

    if (FILT[i]) begin : g_iir
      logic signed [OUT_W:0] diff;
      logic signed [OUT_W:0] sum;
      assign diff = (OUT_W+1)'(x) - (OUT_W+1)'(y[i]);
      assign sum = (OUT_W+1)'(y[i]) + (diff >>> IIR_SHIFT);
      assign nxt[i] = sat(W2'(sum));
    end else begin : g_raw
      assign nxt[i] = x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        y[i] <= '0;
        yv[i] <= 1'b0;
      end else begin
        yv[i] <= vld[i];
        if (vld[i]) y[i] <= nxt[i];
      end
    end
  end

  logic signed [W2-1:0]    ref_prod;
  logic signed [OUT_W-1:0] ref_r;
  logic                    ref_v;

  assign ref_prod = W2'(nxt[2]) * W2'(REF_GAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_r <= '0;
      ref_v <= 1'b0;
    end else begin
      ref_v <= vgrid_vld;
      if (vgrid_vld) ref_r <= sat(ref_prod >>> FRAC_W);
    end
  end

  assign vbat_q = y[0];
  assign vbus_q = y[1];
  assign vgrid_q = y[2];
  assign igrid_q = y[3];
  assign vbat_qv = yv[0];
  assign vbus_qv = yv[1];
  assign vgrid_qv = yv[2];
  assign igrid_qv = yv[3];
  assign ref_q = ref_r;
  assign ref_qv = ref_v;
endmodule

// File: rtl/adc_recon_chk.sv
module adc_recon_chk #(
  parameter int CODE_W = 12,
  parameter int OUT_W = 32,
  parameter logic signed [OUT_W-1:0] SCALE_IGRID = 960
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] vbat_code,
  input logic              vbat_vld,
  input logic              vbus_vld,
  input logic              vgrid_vld,
  input logic [CODE_W-1:0] igrid_code,
  input logic              igrid_vld,
  input logic [OUT_W-1:0]  vbat_q,
  input logic              vbat_qv,
  input logic [OUT_W-1:0]  vbus_q,
  input logic              vbus_qv,
  input logic [OUT_W-1:0]  vgrid_q,
  input logic              vgrid_qv,
  input logic [OUT_W-1:0]  igrid_q,
  input logic              igrid_qv,
  input logic [OUT_W-1:0]  ref_q,
  input logic              ref_qv
);
  localparam int MID = 1 << (CODE_W - 1);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (vbat_q == '0 && vbus_q == '0 && vgrid_q == '0 && igrid_q == '0 && ref_q == '0 &&
                !vbat_qv && !vbus_qv && !vgrid_qv && !igrid_qv && !ref_qv));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({vbat_qv, vbus_qv, vgrid_qv, igrid_qv, ref_qv} ==
              $past({vbat_vld, vbus_vld, vgrid_vld, igrid_vld, vgrid_vld})));

  assert_ref_pairs_grid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_qv == vgrid_qv);

  assert_center_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (igrid_vld && igrid_code == CODE_W'(MID)) |=> (igrid_q == '0));

  assert_no_wrap_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (SCALE_IGRID > 0 && igrid_vld && igrid_code > CODE_W'(MID)) |=> !igrid_q[OUT_W-1]);

  assert_no_wrap_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (SCALE_IGRID > 0 && igrid_vld && igrid_code < CODE_W'(MID)) |=> igrid_q[OUT_W-1]);

  assert_decay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vbat_vld && vbat_code == '0) |=> ($signed(vbat_q) <= $signed($past(vbat_q))));

  assert_hold_vbat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vbat_vld |=> $stable(vbat_q));
  assert_hold_vbus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_vld |=> $stable(vbus_q));
  assert_hold_grid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vgrid_vld |=> ($stable(vgrid_q) && $stable(ref_q)));
  assert_hold_igrid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !igrid_vld |=> $stable(igrid_q));
endmodule

bind adc_recon adc_recon_chk #(.CODE_W(CODE_W), .OUT_W(OUT_W), .SCALE_IGRID(SCALE_IGRID)) u_chk (.*);

// File: tb/sim_adc_recon.sv
`timescale 1ns/1ps
module sim_adc_recon;
  localparam longint SB = 960, SV = 1600, SG = 6400, SI = 2097152, RG = 327;
  localparam longint MAXV = 64'sd2147483647, MINV = -64'sd2147483648;

  logic clk = 1'b0;
  logic rst_n;
  logic [11:0] vbat_code = '0, vbus_code = '0, vgrid_code = '0, igrid_code = '0;
  logic vbat_vld = 1'b0, vbus_vld = 1'b0, vgrid_vld = 1'b0, igrid_vld = 1'b0;
  logic [31:0] vbat_q, vbus_q, vgrid_q, igrid_q, ref_q;
  logic vbat_qv, vbus_qv, vgrid_qv, igrid_qv, ref_qv;

  int errors = 0;
  int checks = 0;
  longint qb[$], qv[$], qg[$], qi[$], qr[$];
  longint my0 = 0, my1 = 0, my2 = 0, lasti = 0, lastr = 0;

  always #2 clk = ~clk;

  adc_recon #(.SCALE_VBAT(32'(SB)), .SCALE_VBUS(32'(SV)), .SCALE_VGRID(32'(SG)),
              .SCALE_IGRID(32'(SI)), .REF_GAIN(32'(RG))) u0 (
    .clk(clk), .rst_n(rst_n),
    .vbat_code(vbat_code), .vbat_vld(vbat_vld), .vbus_code(vbus_code), .vbus_vld(vbus_vld),
    .vgrid_code(vgrid_code), .vgrid_vld(vgrid_vld), .igrid_code(igrid_code), .igrid_vld(igrid_vld),
    .vbat_q(vbat_q), .vbat_qv(vbat_qv), .vbus_q(vbus_q), .vbus_qv(vbus_qv),
    .vgrid_q(vgrid_q), .vgrid_qv(vgrid_qv), .igrid_q(igrid_q), .igrid_qv(igrid_qv),
    .ref_q(ref_q), .ref_qv(ref_qv));

  function automatic longint satv(longint p);
    if (p > MAXV) return MAXV;
    if (p < MINV) return MINV;
    return p;
  endfunction

  function automatic longint s32(logic [31:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(bit [3:0] m, logic [11:0] cb, logic [11:0] cv, logic [11:0] cg, logic [11:0] ci);
    longint x;
    @(negedge clk);
    vbat_code = cb; vbus_code = cv; vgrid_code = cg; igrid_code = ci;
    vbat_vld = m[0]; vbus_vld = m[1]; vgrid_vld = m[2]; igrid_vld = m[3];
    if (m[0]) begin
      x = satv(longint'(cb) * SB);
      my0 = my0 + ((x - my0) >>> 4);
      qb.push_back(my0);
    end
    if (m[1]) begin
      x = satv(longint'(cv) * SV);
      my1 = my1 + ((x - my1) >>> 4);
      qv.push_back(my1);
    end
    if (m[2]) begin
      x = satv((longint'(cg) - 2048) * SG);
      my2 = my2 + ((x - my2) >>> 4);
      qg.push_back(my2);
      lastr = satv((my2 * RG) >>> 16);
      qr.push_back(lastr);
    end
    if (m[3]) begin
      lasti = satv((longint'(ci) - 2048) * SI);
      qi.push_back(lasti);
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    vbat_vld = 1'b0; vbus_vld = 1'b0; vgrid_vld = 1'b0; igrid_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_check();
    check(s32(vbat_q) == my0 && !vbat_qv, "R9 vbat hold", s32(vbat_q), my0);
    check(s32(vbus_q) == my1 && !vbus_qv, "R9 vbus hold", s32(vbus_q), my1);
    check(s32(vgrid_q) == my2 && !vgrid_qv, "R9 vgrid hold", s32(vgrid_q), my2);
    check(s32(igrid_q) == lasti && !igrid_qv, "R9 igrid hold", s32(igrid_q), lasti);
    check(s32(ref_q) == lastr && !ref_qv, "R9 ref hold", s32(ref_q), lastr);
  endtask

  always @(negedge clk) begin
    longint e;
    if (rst_n === 1'b1) begin
      if (vbat_qv) begin
        if (qb.size() == 0) check(0, "R2 vbat extra valid", 1, 0);
        else begin e = qb.pop_front(); check(s32(vbat_q) == e, "R3/R6 vbat", s32(vbat_q), e); end
      end
      if (vbus_qv) begin
        if (qv.size() == 0) check(0, "R2 vbus extra valid", 1, 0);
        else begin e = qv.pop_front(); check(s32(vbus_q) == e, "R3/R6 vbus", s32(vbus_q), e); end
      end
      if (vgrid_qv) begin
        if (qg.size() == 0) check(0, "R2 vgrid extra valid", 1, 0);
        else begin e = qg.pop_front(); check(s32(vgrid_q) == e, "R4/R6 vgrid", s32(vgrid_q), e); end
      end
      if (igrid_qv) begin
        if (qi.size() == 0) check(0, "R2 igrid extra valid", 1, 0);
        else begin e = qi.pop_front(); check(s32(igrid_q) == e, "R4/R5/R7 igrid", s32(igrid_q), e); end
      end
      if (ref_qv) begin
        if (qr.size() == 0) check(0, "R2 ref extra valid", 1, 0);
        else begin e = qr.pop_front(); check(s32(ref_q) == e, "R8 ref", s32(ref_q), e); end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(vbat_q == 0 && vbus_q == 0 && vgrid_q == 0 && igrid_q == 0 && ref_q == 0 &&
          !vbat_qv && !vbus_qv && !vgrid_qv && !igrid_qv && !ref_qv,
          "R1 reset state", s32(vbat_q | vbus_q | vgrid_q | igrid_q | ref_q), 0);
    rst_n = 1'b1;
    idle(1);

    for (int k = 0; k < 3; k++) drive(4'b0001, 12'd4095, 0, 0, 0);
    drive(4'b0001, 12'd0, 0, 0, 0);
    drive(4'b0001, 12'd0, 0, 0, 0);
    idle(3);
    hold_check();

    drive(4'b0010, 0, 12'd1000, 0, 0);
    drive(4'b0010, 0, 12'd1000, 0, 0);
    idle(1);
    drive(4'b0010, 0, 12'd0, 0, 0);

    drive(4'b0100, 0, 0, 12'd2048, 0);
    drive(4'b0100, 0, 0, 12'd3000, 0);
    drive(4'b0100, 0, 0, 12'd4095, 0);
    drive(4'b0100, 0, 0, 12'd3000, 0);
    drive(4'b0100, 0, 0, 12'd2048, 0);
    drive(4'b0100, 0, 0, 12'd1000, 0);
    drive(4'b0100, 0, 0, 12'd0, 0);
    drive(4'b0100, 0, 0, 12'd0, 0);
    drive(4'b0100, 0, 0, 12'd1000, 0);

    drive(4'b1000, 0, 0, 0, 12'd2048);
    drive(4'b1000, 0, 0, 0, 12'd2049);
    drive(4'b1000, 0, 0, 0, 12'd4095);
    drive(4'b1000, 0, 0, 0, 12'd0);
    drive(4'b1000, 0, 0, 0, 12'd1000);
    drive(4'b1000, 0, 0, 0, 12'd2047);
    idle(2);
    hold_check();

    drive(4'b1111, 12'd2000, 12'd3000, 12'd3500, 12'd2100);
    drive(4'b0101, 12'd2500, 12'd0, 12'd500, 12'd0);
    drive(4'b1010, 12'd0, 12'd4000, 12'd0, 12'd1900);
    drive(4'b1111, 12'd4095, 12'd4095, 12'd4095, 12'd4095);
    idle(3);
    hold_check();

    check(qb.size() + qv.size() + qg.size() + qi.size() + qr.size() == 0,
          "R2 missing output valids", longint'(qb.size() + qv.size() + qg.size() + qi.size() + qr.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule